// File: doc/BRIEF.md
# Secondary-Bus Target Admission Control

This block sits on the target side of a bus bridge. A secondary-bus initiator starts a memory read or a memory write. For each one, the block decides whether to accept the cycle or to end it with a retry termination. It holds only the state that this decision needs:

- a small table of outstanding delayed reads, keyed by address tag and initiator;
- a starvation guard that remembers one initiator whose write was retried.

The read data and the posted-write storage live elsewhere. The block reports the verdict one clock after the request strobe. Reads are handled as delayed transactions. A first attempt that is not blocked is entered in the table and told to retry, and the enqueue strobe tells the upstream side to fetch the data. The same initiator later repeats the same request. It is accepted once the completion for its table slot has arrived and no earlier posted write still has to drain ahead of it. An accepted read frees its slot, and the slot index is reported with the verdict.

Writes are accepted unless one of these holds:

- the posted-write buffer is full;
- a lock is held;
- a CSR write hazard exists;
- the starvation guard reserves write admission for a different initiator.

Top module: `sec_tgt_admit`

## Requirements
- R1: After reset there is no response and no enqueue, the delayed-read table is empty and the starvation guard holds no initiator.
- R2: A read that matches no table entry while every table slot is occupied is retried without an enqueue.
- R3: A read that matches no table entry, with a free slot and no lock or CSR hazard, is retried and enqueued into the lowest-numbered free slot. The strobe carries that slot index, the address tag and the initiator ID.
- R4: A read that matches a table entry (same address tag and same initiator) whose completion bit is 0 is retried.
- R5: A read that matches an entry whose completion bit is 1 is retried while ordering-pending is 1. Otherwise it is accepted, its slot index is reported on the response, and the slot is freed.
- R6: A request with the CSR-space flag set is retried while the CSR-write-busy input is 1, for reads and writes alike.
- R7: Every request is retried while lock-held is 1.
- R8: A write is retried while the posted-write buffer is full.
- R9: A write that is retried while the guard is empty records its initiator. While an initiator is recorded, writes from any other initiator are retried.
- R10: When the recorded initiator's write is accepted, the guard returns to empty.
- R11: A response is given exactly one clock after each request strobe. It is either accept or retry, never both. Accept occurs only when no retry condition holds, and several concurrent conditions still give a single retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_wr | input | 1 | 1 = memory write, 0 = memory read |
| req_csr | input | 1 | Request targets CSR space |
| req_id | input | ID_W | Initiator ID |
| req_addr | input | ADDR_W | Address tag of the request |
| pw_full | input | 1 | Posted-write buffer has no free space |
| dq_done | input | DQ_DEPTH | Per-slot completion-arrived flags |
| ord_pending | input | 1 | An earlier posted write must finish first |
| csr_busy | input | 1 | An earlier posted CSR write is unfinished |
| lock_held | input | 1 | Lock from the upstream side is established |
| rsp_valid | output | 1 | Verdict present |
| rsp_accept | output | 1 | Cycle accepted |
| rsp_retry | output | 1 | Cycle answered with retry |
| rsp_slot | output | SLOT_W | Slot supplying data for an accepted read |
| enq_stb | output | 1 | New delayed read entered |
| enq_slot | output | SLOT_W | Slot the new read occupies |
| enq_id | output | ID_W | Initiator of the new read |
| enq_addr | output | ADDR_W | Address tag of the new read |

## Verification
The assertions assume three things about the inputs:

- each request is a single-cycle strobe whose fields are valid with it;
- the completion bit of a slot is 0 from the moment that slot is filled until its completion arrives;
- the level flags (lock, CSR busy, buffer full, ordering) are sampled at the strobe's clock edge.

The bench honours this. Its model sets a slot's completion bit only while the slot is occupied, and clears it in the same cycle the slot is freed. It drives all inputs on the falling edge, so each verdict depends only on the values present at the rising edge.

// File: rtl/sta_pkg.sv
package sta_pkg;

  typedef struct packed {
    logic accept;
    logic retry;
    logic enq;
    logic retire;
  } sta_verdict_t;

  // Lock or CSR hazard: blocks any request before table or buffer checks.
  function automatic logic global_block(logic lock_held, logic req_csr, logic csr_busy);
    return lock_held | (req_csr & csr_busy);
  endfunction

  // Read decision once the table lookup is known.
  function automatic sta_verdict_t rd_verdict(logic blocked, logic hit, logic hit_done,
                                              logic ord_pending, logic full);
    sta_verdict_t v;
    v = '0;
    if (blocked) begin
      v.retry = 1'b1;
    end else if (hit) begin
      if (hit_done && !ord_pending) begin
        v.accept = 1'b1;
        v.retire = 1'b1;
      end else begin
        v.retry = 1'b1;
      end
    end else begin
      v.retry = 1'b1;
      v.enq   = !full;
    end
    return v;
  endfunction

  // Write decision: any single blocking reason forces retry.
  function automatic sta_verdict_t wr_verdict(logic blocked, logic pw_full, logic starve_block);
    sta_verdict_t v;
    v        = '0;
    v.retry  = blocked | pw_full | starve_block;
    v.accept = !v.retry;
    return v;
  endfunction

endpackage

// File: rtl/sta_tag_table.sv
module sta_tag_table #(
  parameter int DQ_DEPTH = 4,
  parameter int ID_W     = 4,
  parameter int ADDR_W   = 16,
  parameter int SLOT_W   = (DQ_DEPTH > 1) ? $clog2(DQ_DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   lk_addr,
  input  logic [ID_W-1:0]     lk_id,
  input  logic [DQ_DEPTH-1:0] dq_done,
  input  logic                fill_en,
  input  logic                free_en,
  output logic                hit,
  output logic                hit_done,
  output logic [SLOT_W-1:0]   hit_slot,
  output logic                full,
  output logic [SLOT_W-1:0]   free_slot,
  output logic [DQ_DEPTH-1:0] slot_vld
);

  logic [DQ_DEPTH-1:0] vld_q;
  logic [ADDR_W-1:0]   addr_q [DQ_DEPTH];
  logic [ID_W-1:0]     id_q   [DQ_DEPTH];
  logic [DQ_DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DQ_DEPTH; g++) begin : g_slot
    assign hit_vec[g] = vld_q[g] && (addr_q[g] == lk_addr) && (id_q[g] == lk_id);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        addr_q[g] <= '0;
        id_q[g]   <= '0;
      end else if (fill_en && (free_slot == SLOT_W'(g))) begin
        vld_q[g]  <= 1'b1;
        addr_q[g] <= lk_addr;
        id_q[g]   <= lk_id;
      end else if (free_en && (hit_slot == SLOT_W'(g))) begin
        vld_q[g]  <= 1'b0;
      end
    end
  end

  always_comb begin
    hit_slot = '0;
    for (int i = DQ_DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_slot = SLOT_W'(i);
    end
  end

  always_comb begin
    free_slot = '0;
    for (int i = DQ_DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_slot = SLOT_W'(i);
    end
  end

  assign hit      = |hit_vec;
  assign hit_done = |(hit_vec & dq_done);
  assign full     = &vld_q;
  assign slot_vld = vld_q;

endmodule

// File: rtl/sta_starve_guard.sv
module sta_starve_guard #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic [ID_W-1:0] arm_id,
  input  logic            release_i,
  output logic            own_vld,
  output logic [ID_W-1:0] own_id
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_vld <= 1'b0;
      own_id  <= '0;
    end else if (release_i) begin
      own_vld <= 1'b0;
    end else if (arm && !own_vld) begin
      own_vld <= 1'b1;
      own_id  <= arm_id;
    end
  end

endmodule

// File: rtl/sta_decide.sv
module sta_decide
  import sta_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            req_valid,
  input  logic            req_wr,
  input  logic            req_csr,
  input  logic [ID_W-1:0] req_id,
  input  logic            pw_full,
  input  logic            ord_pending,
  input  logic            csr_busy,
  input  logic            lock_held,
  input  logic            hit,
  input  logic            hit_done,
  input  logic            full,
  input  logic            own_vld,
  input  logic [ID_W-1:0] own_id,
  output sta_verdict_t    verdict,
  output logic            arm,
  output logic            release_o
);

  logic         blocked;
  logic         starve_block;
  sta_verdict_t rd_v;
  sta_verdict_t wr_v;

  assign blocked      = global_block(lock_held, req_csr, csr_busy);
  assign starve_block = own_vld && (own_id != req_id);
  assign rd_v         = rd_verdict(blocked, hit, hit_done, ord_pending, full);
  assign wr_v         = wr_verdict(blocked, pw_full, starve_block);

  always_comb begin
    verdict = '0;
    if (req_valid) verdict = req_wr ? wr_v : rd_v;
  end

  assign arm       = req_valid && req_wr && wr_v.retry;
  assign release_o = req_valid && req_wr && wr_v.accept && own_vld && (own_id == req_id);

endmodule

// File: rtl/sec_tgt_admit.sv
module sec_tgt_admit
  import sta_pkg::*;
#(
  parameter int DQ_DEPTH = 4,
  parameter int ID_W     = 4,
  parameter int ADDR_W   = 16,
  parameter int SLOT_W   = (DQ_DEPTH > 1) ? $clog2(DQ_DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_wr,
  input  logic                req_csr,
  input  logic [ID_W-1:0]     req_id,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                pw_full,
  input  logic [DQ_DEPTH-1:0] dq_done,
  input  logic                ord_pending,
  input  logic                csr_busy,
  input  logic                lock_held,
  output logic                rsp_valid,
  output logic                rsp_accept,
  output logic                rsp_retry,
  output logic [SLOT_W-1:0]   rsp_slot,
  output logic                enq_stb,
  output logic [SLOT_W-1:0]   enq_slot,
  output logic [ID_W-1:0]     enq_id,
  output logic [ADDR_W-1:0]   enq_addr
);

  // named internal events, also used by the bound checker
  logic                rd_hit;
  logic                rd_hit_done;
  logic [SLOT_W-1:0]   rd_hit_slot;
  logic                tbl_full;
  logic [SLOT_W-1:0]   tbl_free_slot;
  logic [DQ_DEPTH-1:0] tbl_vld;
  logic                own_vld;
  logic [ID_W-1:0]     own_id;
  logic                guard_arm;
  logic                guard_rel;
  sta_verdict_t        verdict;

  sta_tag_table #(
    .DQ_DEPTH(DQ_DEPTH), .ID_W(ID_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_addr  (req_addr),
    .lk_id    (req_id),
    .dq_done  (dq_done),
    .fill_en  (verdict.enq),
    .free_en  (verdict.retire),
    .hit      (rd_hit),
    .hit_done (rd_hit_done),
    .hit_slot (rd_hit_slot),
    .full     (tbl_full),
    .free_slot(tbl_free_slot),
    .slot_vld (tbl_vld)
  );

  sta_starve_guard #(.ID_W(ID_W)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (guard_arm),
    .arm_id   (req_id),
    .release_i(guard_rel),
    .own_vld  (own_vld),
    .own_id   (own_id)
  );

  sta_decide #(.ID_W(ID_W)) u_decide (
    .req_valid  (req_valid),
    .req_wr     (req_wr),
    .req_csr    (req_csr),
    .req_id     (req_id),
    .pw_full    (pw_full),
    .ord_pending(ord_pending),
    .csr_busy   (csr_busy),
    .lock_held  (lock_held),
    .hit        (rd_hit),
    .hit_done   (rd_hit_done),
    .full       (tbl_full),
    .own_vld    (own_vld),
    .own_id     (own_id),
    .verdict    (verdict),
    .arm        (guard_arm),
    .release_o  (guard_rel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_accept <= 1'b0;
      rsp_retry  <= 1'b0;
      rsp_slot   <= '0;
      enq_stb    <= 1'b0;
      enq_slot   <= '0;
      enq_id     <= '0;
      enq_addr   <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_accept <= verdict.accept;
      rsp_retry  <= verdict.retry;
      rsp_slot   <= verdict.retire ? rd_hit_slot : '0;
      enq_stb    <= verdict.enq;
      enq_slot   <= verdict.enq ? tbl_free_slot : '0;
      enq_id     <= verdict.enq ? req_id : '0;
      enq_addr   <= verdict.enq ? req_addr : '0;
    end
  end

endmodule

// File: rtl/sec_tgt_admit_chk.sv
module sec_tgt_admit_chk #(
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_wr,
  input logic            req_csr,
  input logic [ID_W-1:0] req_id,
  input logic            pw_full,
  input logic            ord_pending,
  input logic            csr_busy,
  input logic            lock_held,
  input logic            rsp_valid,
  input logic            rsp_accept,
  input logic            rsp_retry,
  input logic            enq_stb,
  input logic            rd_hit,
  input logic            rd_hit_done,
  input logic            tbl_full,
  input logic            own_vld,
  input logic [ID_W-1:0] own_id
);

  a_r11_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_accept, rsp_retry}) == 1);

  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_accept && !rsp_retry && !enq_stb);

  a_r3_enq_is_retry: assert property (@(posedge clk) disable iff (!rst_n)
    enq_stb |-> rsp_retry);

  a_r2_full_no_enq: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_wr && !lock_held && !(req_csr && csr_busy) && !rd_hit && tbl_full
    |=> rsp_retry && !enq_stb);

  a_r4_pending_retry: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_wr && rd_hit && !rd_hit_done |=> rsp_retry);

  a_r5_order_retry: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_wr && rd_hit && ord_pending |=> rsp_retry);

  a_r6_csr_retry: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_csr && csr_busy |=> rsp_retry);

  a_r7_lock_retry: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && lock_held |=> rsp_retry);

  a_r8_pw_retry: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_wr && pw_full |=> rsp_retry);

  a_r9_starve_retry: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_wr && own_vld && (req_id != own_id) |=> rsp_retry);

  a_r9_arm_record: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_wr && !own_vld && (lock_held || pw_full)
    |=> own_vld && (own_id == $past(req_id)));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_wr && own_vld && (req_id == own_id) && !lock_held && !pw_full
    && !(req_csr && csr_busy) |=> !own_vld);

endmodule

bind sec_tgt_admit sec_tgt_admit_chk #(.ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_wr     (req_wr),
  .req_csr    (req_csr),
  .req_id     (req_id),
  .pw_full    (pw_full),
  .ord_pending(ord_pending),
  .csr_busy   (csr_busy),
  .lock_held  (lock_held),
  .rsp_valid  (rsp_valid),
  .rsp_accept (rsp_accept),
  .rsp_retry  (rsp_retry),
  .enq_stb    (enq_stb),
  .rd_hit     (rd_hit),
  .rd_hit_done(rd_hit_done),
  .tbl_full   (tbl_full),
  .own_vld    (own_vld),
  .own_id     (own_id)
);

// File: tb/sec_tgt_admit_bench.sv
module sec_tgt_admit_bench;
  localparam int DQ = 2;
  localparam int IW = 2;
  localparam int AW = 2;
  localparam int SW = 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_wr, req_csr;
  logic [IW-1:0] req_id;
  logic [AW-1:0] req_addr;
  logic          pw_full, ord_pending, csr_busy, lock_held;
  logic [DQ-1:0] dq_done;
  logic          rsp_valid, rsp_accept, rsp_retry, enq_stb;
  logic [SW-1:0] rsp_slot, enq_slot;
  logic [IW-1:0] enq_id;
  logic [AW-1:0] enq_addr;

  sec_tgt_admit #(.DQ_DEPTH(DQ), .ID_W(IW), .ADDR_W(AW), .SLOT_W(SW)) u_sec_tgt_admit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr), .req_csr(req_csr),
    .req_id(req_id), .req_addr(req_addr), .pw_full(pw_full), .dq_done(dq_done),
    .ord_pending(ord_pending), .csr_busy(csr_busy), .lock_held(lock_held),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_retry(rsp_retry),
    .rsp_slot(rsp_slot), .enq_stb(enq_stb), .enq_slot(enq_slot), .enq_id(enq_id),
    .enq_addr(enq_addr));

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  logic [DQ-1:0] m_vld  = '0;
  logic [DQ-1:0] m_done = '0;
  logic [AW-1:0] m_addr [DQ];
  logic [IW-1:0] m_id   [DQ];
  logic          m_own  = 1'b0;
  logic [IW-1:0] m_own_id = '0;

  assign dq_done = m_done;

  function automatic bit [31:0] nxt(bit [31:0] s);
    s = s ^ (s << 13);
    s = s ^ (s >> 17);
    s = s ^ (s << 5);
    return s;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle at a falling edge, predict, then compare at the next falling edge.
  task automatic issue(bit v, bit wr, bit csr, logic [IW-1:0] id, logic [AW-1:0] a,
                       bit pwf, bit ordp, bit cb, bit lk);
    int hs, fs, conds;
    bit e_acc, e_ret, e_enq;
    string tag;
    logic [15:0] act, exp;
    req_valid = v; req_wr = wr; req_csr = csr; req_id = id; req_addr = a;
    pw_full = pwf; ord_pending = ordp; csr_busy = cb; lock_held = lk;
    hs = -1; fs = -1;
    for (int s = 0; s < DQ; s++) begin
      if (hs < 0 && m_vld[s] && m_addr[s] == a && m_id[s] == id) hs = s;
      if (fs < 0 && !m_vld[s]) fs = s;
    end
    e_acc = 1'b0; e_enq = 1'b0; tag = "R11";
    if (v) begin
      if (wr) begin
        conds = int'(lk) + int'(csr && cb) + int'(pwf) + int'(m_own && id != m_own_id);
        e_acc = (conds == 0);
        if (lk) tag = "R7";
        else if (csr && cb) tag = "R6";
        else if (pwf) tag = "R8";
        else if (m_own && id != m_own_id) tag = "R9";
        else if (m_own) tag = "R10";
      end else if (lk) begin
        tag = "R7";
      end else if (csr && cb) begin
        tag = "R6";
      end else if (hs >= 0) begin
        e_acc = m_done[hs] && !ordp;
        tag = m_done[hs] ? "R5" : "R4";
      end else if (fs >= 0) begin
        e_enq = 1'b1; tag = "R3";
      end else begin
        tag = "R2";
      end
    end
    e_ret = v && !e_acc;
    exp = {5'd0, v, e_acc, e_ret, e_enq,
           (e_enq ? 1'(fs) : 1'b0), (e_acc && !wr ? 1'(hs) : 1'b0),
           (e_enq ? id : 2'b00), (e_enq ? a : 2'b00)};
    @(negedge clk);
    act = {5'd0, rsp_valid, rsp_accept, rsp_retry, enq_stb, enq_slot, rsp_slot, enq_id, enq_addr};
    check(tag, act, exp);
    if (e_enq) begin
      m_vld[fs] = 1'b1; m_done[fs] = 1'b0; m_addr[fs] = a; m_id[fs] = id;
    end
    if (v && !wr && e_acc) begin
      m_vld[hs] = 1'b0; m_done[hs] = 1'b0;
    end
    if (v && wr) begin
      if (e_ret && !m_own) begin m_own = 1'b1; m_own_id = id; end
      else if (e_acc && m_own && id == m_own_id) m_own = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: actual=hung expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit [31:0] seed;
    seed = 32'h2545_f491;
    for (int s = 0; s < DQ; s++) begin m_addr[s] = '0; m_id[s] = '0; end
    rst_n = 1'b0;
    req_valid = 0; req_wr = 0; req_csr = 0; req_id = '0; req_addr = '0;
    pw_full = 0; ord_pending = 0; csr_busy = 0; lock_held = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the outputs
    check("R1", {12'd0, rsp_valid, rsp_accept, rsp_retry, enq_stb}, 16'd0);
    rst_n = 1'b1;
    issue(0, 0, 0, 2'd0, 2'd0, 0, 0, 0, 0);                 // R11 idle
    // R1/R3: empty table, first read takes slot 0
    issue(1, 0, 0, 2'd1, 2'd2, 0, 0, 0, 0);
    issue(1, 0, 0, 2'd2, 2'd3, 0, 0, 0, 0);                 // R3 slot 1
    issue(1, 0, 0, 2'd3, 2'd1, 0, 0, 0, 0);                 // R2 full
    issue(1, 0, 0, 2'd1, 2'd2, 0, 0, 0, 0);                 // R4 pending
    m_done[0] = 1'b1;
    issue(1, 0, 0, 2'd1, 2'd2, 0, 1, 0, 0);                 // R5 ordering holds
    issue(1, 0, 1, 2'd1, 2'd2, 0, 0, 1, 0);                 // R6 CSR hazard on read
    issue(1, 0, 0, 2'd1, 2'd2, 0, 0, 0, 1);                 // R7 lock on read
    issue(1, 0, 0, 2'd1, 2'd2, 0, 0, 0, 0);                 // R5 accepted, slot 0
    issue(1, 1, 1, 2'd0, 2'd0, 0, 0, 1, 0);                 // R6 write, arms guard
    issue(1, 1, 0, 2'd2, 2'd0, 0, 0, 0, 0);                 // R9 other initiator
    issue(1, 1, 0, 2'd0, 2'd0, 1, 0, 0, 0);                 // R8 owner, buffer full
    issue(1, 1, 0, 2'd0, 2'd0, 0, 0, 0, 0);                 // R10 owner accepted
    issue(1, 1, 0, 2'd2, 2'd0, 0, 0, 0, 0);                 // R10 guard released
    issue(1, 1, 1, 2'd3, 2'd0, 1, 1, 1, 1);                 // R11 many causes, one retry
    issue(1, 1, 0, 2'd3, 2'd0, 0, 0, 0, 0);                 // owner accepted
    // near-exhaustive sweep over the small configuration
    for (int k = 0; k < 4000; k++) begin
      seed = nxt(seed);
      for (int s = 0; s < DQ; s++)
        if (m_vld[s] && seed[20+s*2 +: 2] == 2'b00) m_done[s] = 1'b1;
      issue(seed[2:0] != 3'd0, seed[3], seed[4], seed[6:5], seed[8:7],
            seed[10:9] == 2'b00, seed[12:11] == 2'b00, seed[13],
            seed[17:14] == 4'd0);
    end
    issue(0, 0, 0, 2'd0, 2'd0, 0, 0, 0, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule